// File: doc/BRIEF.md
# Buffered Asynchronous Serial Transmitter

This block turns bytes into asynchronous serial frames on a single output line. A byte written through the write strobe lands in a one-entry holding buffer. On the next bit boundary at which the shifter is free, the byte moves into a frame shift register. That register sends a low start bit, then the data bits least significant first, then an optional parity bit, then one or two high stop bits. The line rests high between frames.

Bit timing comes from an external tick. The tick is optionally divided by four, then divided by a programmable reload count, and the result is oversampled sixteen times per bit. Control inputs select the character length, parity enable and sense, stop-bit count, and the event that drives the single-cycle interrupt pulse. The interrupt event is either the holding buffer handing its byte to the shifter, or the shifter finishing a whole frame. Two status outputs report whether the buffer is empty and whether the shifter has gone quiet.

Top module: `sertx_core`

## Requirements
- R1: After reset the line is high, buf_empty is 1, shift_done is 1 and tx_irq is 0.
- R2: A frame is one low start bit, then the data bits least significant bit first, then the stop bits, which are high. The line is high whenever no frame is being sent.
- R3: len7=0 sends 8 data bits. len7=1 sends the low 7 bits of wr_data, and bit 7 is dropped.
- R4: With par_en=1, one parity bit follows the data. With par_odd=0 it makes the count of ones in data plus parity even, and with par_odd=1 it makes that count odd.
- R5: stop2=0 ends the frame with one stop bit, and stop2=1 ends it with two.
- R6: Every bit lasts 16*(brg_div+1) source ticks. A source tick is every cycle with tick_in=1 when src_div4=0, and every fourth such cycle when src_div4=1.
- R7: A write clears buf_empty. buf_empty returns to 1 when the byte moves into the shifter at a bit boundary. A write while the buffer is full is ignored.
- R8: shift_done is 0 from the cycle a frame starts until its last stop bit ends, and then it returns to 1.
- R9: With irq_on_done=0, tx_irq pulses for one cycle when the buffer hands its byte to the shifter.
- R10: With irq_on_done=1, tx_irq pulses for one cycle when a frame's last stop bit ends.
- R11: With tx_en=0, no byte leaves the buffer, the line is held high, and any frame in progress is abandoned, so shift_done reads 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_in | input | 1 | Source tick for the baud counter |
| src_div4 | input | 1 | 1 counts every fourth tick_in |
| brg_div | input | 8 | Baud reload; divides by brg_div+1 |
| tx_en | input | 1 | Transmit enable |
| len7 | input | 1 | 1 selects 7 data bits |
| par_en | input | 1 | Append parity bit |
| par_odd | input | 1 | 1 odd parity, 0 even |
| stop2 | input | 1 | 1 selects two stop bits |
| irq_on_done | input | 1 | Interrupt source: 0 buffer empties, 1 frame done |
| wr_en | input | 1 | Write strobe for the holding buffer |
| wr_data | input | 8 | Byte to send |
| txd | output | 1 | Serial data line |
| buf_empty | output | 1 | Holding buffer empty |
| shift_done | output | 1 | Shifter idle |
| tx_irq | output | 1 | One-cycle interrupt pulse |

## Verification
The hardest state to reach from the ports is a holding buffer that is full while the shifter is stalled. In normal running a write is drained at the next bit boundary, so a second write almost never meets a full buffer. The bench therefore writes two different bytes while tx_en is low, checks that the line stays idle with the buffer still full, and then enables the block. It confirms that the first byte is the one sent. A separate test drops tx_en in the middle of a frame to confirm the abort.

// File: rtl/sertx_pkg.sv
package sertx_pkg;
  localparam int DATA_W  = 8;
  localparam int FRAME_W = DATA_W + 4;
  localparam int CNT_W   = $clog2(FRAME_W + 1);

  typedef struct packed {
    logic len7;
    logic par_en;
    logic par_odd;
    logic stop2;
  } fmt_t;

  // Bit 0 leaves first; unused upper positions stay high (stop level).
  function automatic logic [FRAME_W-1:0] pack_frame(input logic [DATA_W-1:0] d,
                                                     input fmt_t f);
    logic [FRAME_W-1:0] fr;
    logic p;
    int nd;
    nd = f.len7 ? DATA_W - 1 : DATA_W;
    fr = '1;
    fr[0] = 1'b0;
    p = f.par_odd;
    for (int i = 0; i < DATA_W; i++) begin
      if (i < nd) begin
        fr[i+1] = d[i];
        p = p ^ d[i];
      end
    end
    if (f.par_en) fr[nd+1] = p;
    return fr;
  endfunction

  function automatic logic [CNT_W-1:0] frame_len(input fmt_t f);
    return CNT_W'(2 + DATA_W - int'(f.len7) + int'(f.par_en) + int'(f.stop2));
  endfunction
endpackage

// File: rtl/sertx_clkgen.sv
module sertx_clkgen #(
  parameter int DIV_W = 8,
  parameter int OVS   = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             tick_in,
  input  logic             src_div4,
  input  logic [DIV_W-1:0] brg_div,
  output logic             bit_tick
);
  localparam int SUB_W = $clog2(OVS);

  logic [1:0]       pre_q, pre_d;
  logic [DIV_W-1:0] brg_q, brg_d;
  logic [SUB_W-1:0] sub_q, sub_d;
  logic             src_tick, brg_pulse;

  assign src_tick  = tick_in && (!src_div4 || pre_q == 2'd3);
  assign brg_pulse = src_tick && (brg_q == '0);
  assign bit_tick  = brg_pulse && (sub_q == SUB_W'(OVS - 1));

  always_comb begin
    pre_d = pre_q;
    brg_d = brg_q;
    sub_d = sub_q;
    if (!run) begin
      pre_d = '0;
      brg_d = '0;
      sub_d = '0;
    end else begin
      if (tick_in)   pre_d = pre_q + 2'd1;
      if (src_tick)  brg_d = brg_pulse ? brg_div : brg_q - 1'b1;
      if (brg_pulse) sub_d = bit_tick ? '0 : sub_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
      brg_q <= '0;
      sub_q <= '0;
    end else begin
      pre_q <= pre_d;
      brg_q <= brg_d;
      sub_q <= sub_d;
    end
  end

  // R11
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !bit_tick);
endmodule

// File: rtl/sertx_holdbuf.sv
module sertx_holdbuf #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  logic         take,
  output logic         full,
  output logic [W-1:0] data
);
  logic         full_d;
  logic [W-1:0] data_d;
  logic         accept;

  assign accept = wr_en && !full;

  always_comb begin
    full_d = full;
    data_d = data;
    if (take)        full_d = 1'b0;
    else if (accept) full_d = 1'b1;
    if (accept)      data_d = wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full <= 1'b0;
      data <= '0;
    end else begin
      full <= full_d;
      data <= data_d;
    end
  end

  // R7
  fill_needs_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(full) |-> $past(wr_en));
  // R7
  full_keeps_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    full && wr_en |=> data == $past(data));
endmodule

// File: rtl/sertx_shifter.sv
module sertx_shifter
  import sertx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              bit_tick,
  input  logic              have_data,
  input  logic [DATA_W-1:0] data,
  input  fmt_t              fmt,
  output logic              take,
  output logic              busy,
  output logic              done_evt,
  output logic              txd
);
  logic [FRAME_W-1:0] sr_q, sr_d;
  logic [CNT_W-1:0]   cnt_q, cnt_d;
  logic               busy_d, last;

  assign last     = busy && (cnt_q == CNT_W'(1));
  assign done_evt = run && bit_tick && last;
  assign take     = run && bit_tick && have_data && (!busy || last);
  assign txd      = sr_q[0];

  always_comb begin
    sr_d   = sr_q;
    cnt_d  = cnt_q;
    busy_d = busy;
    if (!run) begin
      sr_d   = '1;
      cnt_d  = '0;
      busy_d = 1'b0;
    end else if (take) begin
      sr_d   = pack_frame(data, fmt);
      cnt_d  = frame_len(fmt);
      busy_d = 1'b1;
    end else if (bit_tick && busy) begin
      sr_d   = {1'b1, sr_q[FRAME_W-1:1]};
      cnt_d  = cnt_q - 1'b1;
      busy_d = !last;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q  <= '1;
      cnt_q <= '0;
      busy  <= 1'b0;
    end else begin
      sr_q  <= sr_d;
      cnt_q <= cnt_d;
      busy  <= busy_d;
    end
  end

  // R2
  start_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !txd);
  // R11
  abort_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !busy && txd);
endmodule

// File: rtl/sertx_core.sv
module sertx_core
  import sertx_pkg::*;
#(
  parameter int DIV_W = 8,
  parameter int OVS   = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_in,
  input  logic              src_div4,
  input  logic [DIV_W-1:0]  brg_div,
  input  logic              tx_en,
  input  logic              len7,
  input  logic              par_en,
  input  logic              par_odd,
  input  logic              stop2,
  input  logic              irq_on_done,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic              txd,
  output logic              buf_empty,
  output logic              shift_done,
  output logic              tx_irq
);
  logic [1:0]        rst_sync;
  logic              rst_q;
  logic              bit_tick, take, full, busy, done_evt, irq_d;
  logic [DATA_W-1:0] held;
  fmt_t              fmt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_q = rst_sync[1];

  assign fmt = '{len7: len7, par_en: par_en, par_odd: par_odd, stop2: stop2};

  sertx_clkgen #(.DIV_W(DIV_W), .OVS(OVS)) u_clk (
    .clk(clk), .rst_n(rst_q), .run(tx_en), .tick_in(tick_in),
    .src_div4(src_div4), .brg_div(brg_div), .bit_tick(bit_tick));

  sertx_holdbuf #(.W(DATA_W)) u_buf (
    .clk(clk), .rst_n(rst_q), .wr_en(wr_en), .wr_data(wr_data),
    .take(take), .full(full), .data(held));

  sertx_shifter u_sh (
    .clk(clk), .rst_n(rst_q), .run(tx_en), .bit_tick(bit_tick),
    .have_data(full), .data(held), .fmt(fmt), .take(take),
    .busy(busy), .done_evt(done_evt), .txd(txd));

  assign irq_d = irq_on_done ? done_evt : take;

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) tx_irq <= 1'b0;
    else        tx_irq <= irq_d;
  end

  assign buf_empty  = !full;
  assign shift_done = !busy;

  // R9
  irq_on_drain_chk: assert property (@(posedge clk) disable iff (!rst_q)
    $rose(buf_empty) && $past(!irq_on_done) |-> tx_irq);
  // R10
  irq_on_finish_chk: assert property (@(posedge clk) disable iff (!rst_q)
    $rose(shift_done) && $past(tx_en) && $past(irq_on_done) |-> tx_irq);
endmodule

// File: tb/sertx_core_test.sv
module sertx_core_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick_in = 1'b1;
  logic src_div4 = 1'b0;
  logic [7:0] brg_div = '0;
  logic tx_en = 1'b0;
  logic len7 = 1'b0, par_en = 1'b0, par_odd = 1'b0, stop2 = 1'b0, irq_on_done = 1'b0;
  logic wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic txd, buf_empty, shift_done, tx_irq;

  int checks = 0;
  int errors = 0;
  int irq_cnt = 0;
  int cycles = 0;

  always #2 clk = ~clk;

  sertx_core uut (
    .clk(clk), .rst_n(rst_n), .tick_in(tick_in), .src_div4(src_div4),
    .brg_div(brg_div), .tx_en(tx_en), .len7(len7), .par_en(par_en),
    .par_odd(par_odd), .stop2(stop2), .irq_on_done(irq_on_done),
    .wr_en(wr_en), .wr_data(wr_data), .txd(txd), .buf_empty(buf_empty),
    .shift_done(shift_done), .tx_irq(tx_irq));

  always @(negedge clk) if (tx_irq) irq_cnt++;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog act=%0d exp=%0d", cycles, 150000);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  // {nbits[19:16], reload[15:14], div4[13], irqd[12], stop2[11], podd[10], pen[9], len7[8], data[7:0]}
  localparam logic [19:0] VEC [8] = '{
    {4'd10, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'hA5},
    {4'd9,  2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 8'hBC},
    {4'd11, 2'd0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 8'h96},
    {4'd12, 2'd0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 8'h96},
    {4'd10, 2'd0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 8'hFF},
    {4'd11, 2'd2, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 8'h01},
    {4'd11, 2'd1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 8'h5A},
    {4'd11, 2'd0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 8'h00}
  };

  function automatic bit exp_bit(input logic [7:0] d, input bit l7, input bit pe,
                                 input bit po, input int k);
    int nd;
    bit p;
    nd = l7 ? 7 : 8;
    p = po;
    for (int i = 0; i < nd; i++) p ^= d[i];
    if (k == 0) return 1'b0;
    if (k <= nd) return d[k-1];
    if (k == nd + 1 && pe) return p;
    return 1'b1;
  endfunction

  function automatic string bit_req(input bit l7, input bit pe, input int k);
    int nd;
    nd = l7 ? 7 : 8;
    if (k == 0) return "R2 start";
    if (k <= nd) return l7 ? "R3 data" : "R2 data";
    if (k == nd + 1 && pe) return "R4 parity";
    return "R5 stop";
  endfunction

  task automatic write_byte(input logic [7:0] d);
    @(negedge clk);
    irq_cnt = 0;
    wr_en = 1'b1;
    wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic recv(input logic [7:0] d, input bit l7, input bit pe, input bit po,
                      input int nb, input int per, input bit irqd);
    int w;
    w = 0;
    while (txd && w < 5000) begin
      @(negedge clk);
      w++;
    end
    chk(!txd, "R2 start seen", txd, 0);
    repeat (per / 2) @(negedge clk);
    chk(txd == 1'b0, "R2 start bit", txd, 0);
    chk(buf_empty == 1'b1, "R7 drained", buf_empty, 1);
    chk(shift_done == 1'b0, "R8 busy", shift_done, 0);
    if (!irqd) chk(irq_cnt == 1, "R9 irq on drain", irq_cnt, 1);
    for (int k = 1; k < nb; k++) begin
      repeat (per) @(negedge clk);
      chk(txd == exp_bit(d, l7, pe, po, k), bit_req(l7, pe, k), txd,
          exp_bit(d, l7, pe, po, k));
    end
    chk(shift_done == 1'b0, "R5 last stop still busy", shift_done, 0);
    if (irqd) chk(irq_cnt == 0, "R10 no early irq", irq_cnt, 0);
    repeat (per / 2 - 1) @(negedge clk);
    chk(shift_done == 1'b0, "R6 bit length", shift_done, 0);
    @(negedge clk);
    chk(shift_done == 1'b1, "R8 done", shift_done, 1);
    chk(txd == 1'b1, "R2 idle high", txd, 1);
    @(negedge clk);
    if (irqd) chk(irq_cnt == 1, "R10 irq on finish", irq_cnt, 1);
    else      chk(irq_cnt == 1, "R9 single pulse", irq_cnt, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1
    chk(txd == 1'b1, "R1 txd", txd, 1);
    chk(buf_empty == 1'b1, "R1 buf_empty", buf_empty, 1);
    chk(shift_done == 1'b1, "R1 shift_done", shift_done, 1);
    chk(tx_irq == 1'b0, "R1 tx_irq", tx_irq, 0);

    // R11 / R7: stalled buffer, second write ignored
    write_byte(8'hA5);
    chk(buf_empty == 1'b0, "R7 write fills", buf_empty, 0);
    write_byte(8'h3C);
    repeat (200) @(negedge clk);
    chk(txd == 1'b1, "R11 held idle", txd, 1);
    chk(buf_empty == 1'b0, "R11 no drain", buf_empty, 0);
    tx_en = 1'b1;
    recv(8'hA5, 1'b0, 1'b0, 1'b0, 10, 16, 1'b0);

    // table-driven frames
    for (int v = 0; v < 8; v++) begin
      logic [19:0] e;
      int per;
      e = VEC[v];
      brg_div = {6'd0, e[15:14]};
      src_div4 = e[13];
      irq_on_done = e[12];
      stop2 = e[11];
      par_odd = e[10];
      par_en = e[9];
      len7 = e[8];
      per = 16 * (int'(e[15:14]) + 1) * (e[13] ? 4 : 1);
      write_byte(e[7:0]);
      chk(buf_empty == 1'b0, "R7 write fills", buf_empty, 0);
      recv(e[7:0], e[8], e[9], e[10], int'(e[19:16]), per, e[12]);
    end

    // R11: abort a frame in progress
    brg_div = '0; src_div4 = 1'b0; irq_on_done = 1'b0;
    len7 = 1'b0; par_en = 1'b0; par_odd = 1'b0; stop2 = 1'b0;
    write_byte(8'h00);
    begin
      int w;
      w = 0;
      while (txd && w < 5000) begin
        @(negedge clk);
        w++;
      end
    end
    repeat (40) @(negedge clk);
    chk(txd == 1'b0, "R2 data zero mid-frame", txd, 0);
    tx_en = 1'b0;
    @(negedge clk);
    chk(txd == 1'b1, "R11 abort line high", txd, 1);
    chk(shift_done == 1'b1, "R11 abort idle", shift_done, 1);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule